// File: doc/BRIEF.md
# Byte-Addressable Load/Store Port

This block sits between a 32-bit processor core and a word-organized synchronous RAM. It serves byte, halfword and word loads, and sign-extends or zero-extends the loaded value as the core asks. It serves byte, halfword and word stores. A byte or halfword store runs as a read, a lane merge and a write-back, so the other bytes of the addressed word are kept. The core places one request, holds it for a single cycle, and waits for the completion pulse.

Any address with a nonzero bit at or above position `RAM_AW` (17 by default) falls outside RAM and is treated as memory-mapped I/O. Stores there go to a display write port, with byte enables and replicated data. Loads from there return the push-button inputs. An access that is misaligned, or that carries an undefined load code, completes at once with an error flag and touches neither RAM nor the display.

Top module: `lsu_mem_port`

## Requirements
- R1: While reset is high, `rsp_done`, `rsp_err`, `mem_en`, `mem_we` and `disp_we` are low and `rsp_rdata` is zero.
- R2: Load codes: 000 is a signed byte, 100 an unsigned byte, 001 a signed halfword and 101 an unsigned halfword. Byte lane `addr[1:0]` is taken, or halfword lane `addr[1]`. The upper bits are filled with the lane's top bit for signed codes and with zeros for unsigned codes.
- R3: Load code 010 returns the whole word. Store code 11 writes the whole word in a single RAM write cycle, with no read before it.
- R4: Store codes 01 (byte) and 10 (halfword) read the addressed word, replace only the selected lanes, and write it back to the same word. Exactly two RAM accesses are made, and every other byte keeps its value.
- R5: Store code 00 completes with no RAM access, no display write and no error.
- R6: A halfword access with `addr[0]`=1, a word access with `addr[1:0]`≠0, or a load code of 011, 110 or 111 completes with `rsp_err` high. No RAM access and no display write are made.
- R7: A valid store whose address has any bit set at or above `RAM_AW` pulses `disp_we` once and makes no RAM access. It carries the low `RAM_AW` address bits, byte enables (bit n is lane n), and the store data replicated across the lanes.
- R8: A valid load from the I/O region returns `btn_in` zero-extended to 32 bits and makes no RAM access.
- R9: `rsp_done` pulses for one cycle per request. `rsp_rdata` changes only with the completion of a load and otherwise keeps the last loaded value.
- R10: Counting the edge that samples `req_valid` as the first, `rsp_done` rises after that edge for an immediate completion (error, store code 00, or I/O). It rises after the second edge for a RAM word store, the third for a RAM load and the fourth for a RAM sub-word store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe, sampled when idle |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| req_ld_code | input | 3 | Load width and extension code |
| req_st_code | input | 2 | Store width code |
| rsp_done | output | 1 | Completion pulse |
| rsp_err | output | 1 | Error flag, valid with `rsp_done` |
| rsp_rdata | output | 32 | Last loaded value |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | RAM_AW-2 | RAM word address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, one cycle after a read |
| disp_we | output | 1 | Display write strobe |
| disp_addr | output | RAM_AW | Display byte address |
| disp_be | output | 4 | Display byte enables |
| disp_data | output | 32 | Display data, lane-replicated |
| btn_in | input | BTN_W | Push-button state |

## Verification
The hardest case to reach is a sub-word store whose merge has to keep bytes that a previous operation changed. A word store alone cannot show that. The stimulus first writes a known word with a full-width store. It then lays byte and halfword stores on different lanes of the same word, and reads the word back in full. A wrong lane or a stale read shows up in the bytes that were not targeted. Accesses at the last RAM word and just above the RAM range check the region split. Counting RAM enables per request shows that error, no-write and I/O requests never reach memory.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  // load codes (width in [1:0], unsigned flag in [2])
  localparam logic [2:0] LD_SB = 3'b000;
  localparam logic [2:0] LD_SH = 3'b001;
  localparam logic [2:0] LD_W  = 3'b010;
  localparam logic [2:0] LD_UB = 3'b100;
  localparam logic [2:0] LD_UH = 3'b101;

  // store codes
  localparam logic [1:0] ST_NONE = 2'b00;
  localparam logic [1:0] ST_B    = 2'b01;
  localparam logic [1:0] ST_H    = 2'b10;
  localparam logic [1:0] ST_W    = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LD_WAIT,
    S_LD_CAP,
    S_ST_RD,
    S_ST_MRG,
    S_ST_WR
  } lsu_state_e;

  typedef struct packed {
    logic       is_io;
    logic       bad;
    logic [3:0] be;
  } lsu_chk_t;

endpackage

// File: rtl/lsu_addr_check.sv
module lsu_addr_check
  import lsu_pkg::*;
#(
  parameter int RAM_AW = 17
) (
  input  logic        is_store,
  input  logic [31:0] addr,
  input  logic [2:0]  ld_code,
  input  logic [1:0]  st_code,
  output lsu_chk_t    chk
);

  logic [1:0] off;
  assign off = addr[1:0];

  always_comb begin
    chk.is_io = |addr[31:RAM_AW];
    chk.bad   = 1'b0;
    chk.be    = 4'b0000;
    if (is_store) begin
      case (st_code)
        ST_B: chk.be = 4'b0001 << off;
        ST_H: begin
          chk.bad = off[0];
          chk.be  = 4'b0011 << {off[1], 1'b0};
        end
        ST_W: begin
          chk.bad = |off;
          chk.be  = 4'b1111;
        end
        default: chk.be = 4'b0000;
      endcase
    end else begin
      case (ld_code)
        LD_SB, LD_UB: chk.bad = 1'b0;
        LD_SH, LD_UH: chk.bad = off[0];
        LD_W:         chk.bad = |off;
        default:      chk.bad = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_pkg::*;
(
  input  logic [31:0] word,
  input  logic [1:0]  off,
  input  logic [2:0]  code,
  output logic [31:0] val
);

  logic [31:0] shifted;
  logic        fill;

  assign shifted = word >> {off, 3'b000};

  always_comb begin
    fill = 1'b0;
    case (code[1:0])
      2'b00: begin
        fill = ~code[2] & shifted[7];
        val  = {{24{fill}}, shifted[7:0]};
      end
      2'b01: begin
        fill = ~code[2] & shifted[15];
        val  = {{16{fill}}, shifted[15:0]};
      end
      default: val = shifted;
    endcase
  end

endmodule

// File: rtl/lsu_store_merge.sv
module lsu_store_merge #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] old_word,
  input  logic [8*LANES-1:0] new_word,
  input  logic [LANES-1:0]   be,
  output logic [8*LANES-1:0] merged
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[8*g +: 8] = be[g] ? new_word[8*g +: 8] : old_word[8*g +: 8];
  end

endmodule

// File: rtl/lsu_mem_port.sv
module lsu_mem_port
  import lsu_pkg::*;
#(
  parameter int RAM_AW = 17,
  parameter int BTN_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_store,
  input  logic [31:0]         req_addr,
  input  logic [31:0]         req_wdata,
  input  logic [2:0]          req_ld_code,
  input  logic [1:0]          req_st_code,
  output logic                rsp_done,
  output logic                rsp_err,
  output logic [31:0]         rsp_rdata,
  output logic                mem_en,
  output logic                mem_we,
  output logic [RAM_AW-3:0]   mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic [31:0]         mem_rdata,
  output logic                disp_we,
  output logic [RAM_AW-1:0]   disp_addr,
  output logic [3:0]          disp_be,
  output logic [31:0]         disp_data,
  input  logic [BTN_W-1:0]    btn_in
);

  localparam int WORD_AW = RAM_AW - 2;
  localparam int BTN_PAD = 32 - BTN_W;

  lsu_state_e  state_q;
  lsu_chk_t    chk;
  logic [31:0] wrep;
  logic [31:0] wrep_q;
  logic [1:0]  off_q;
  logic [2:0]  code_q;
  logic [3:0]  be_q;
  logic [31:0] ld_val;
  logic [31:0] merged;

  lsu_addr_check #(.RAM_AW(RAM_AW)) u_check (
    .is_store (req_store),
    .addr     (req_addr),
    .ld_code  (req_ld_code),
    .st_code  (req_st_code),
    .chk      (chk)
  );

  lsu_load_align u_align (
    .word (mem_rdata),
    .off  (off_q),
    .code (code_q),
    .val  (ld_val)
  );

  lsu_store_merge #(.LANES(4)) u_merge (
    .old_word (mem_rdata),
    .new_word (wrep_q),
    .be       (be_q),
    .merged   (merged)
  );

  always_comb begin
    case (req_st_code)
      ST_B:    wrep = {4{req_wdata[7:0]}};
      ST_H:    wrep = {2{req_wdata[15:0]}};
      default: wrep = req_wdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      disp_we   <= 1'b0;
      disp_addr <= '0;
      disp_be   <= '0;
      disp_data <= '0;
      wrep_q    <= '0;
      off_q     <= '0;
      code_q    <= '0;
      be_q      <= '0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      mem_en   <= 1'b0;
      mem_we   <= 1'b0;
      disp_we  <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            off_q  <= req_addr[1:0];
            code_q <= req_ld_code;
            be_q   <= chk.be;
            wrep_q <= wrep;
            if (chk.bad) begin
              rsp_done <= 1'b1;
              rsp_err  <= 1'b1;
            end else if (req_store) begin
              if (req_st_code == ST_NONE) begin
                rsp_done <= 1'b1;
              end else if (chk.is_io) begin
                disp_we   <= 1'b1;
                disp_addr <= req_addr[RAM_AW-1:0];
                disp_be   <= chk.be;
                disp_data <= wrep;
                rsp_done  <= 1'b1;
              end else begin
                mem_en   <= 1'b1;
                mem_addr <= req_addr[RAM_AW-1:2];
                if (req_st_code == ST_W) begin
                  mem_we    <= 1'b1;
                  mem_wdata <= wrep;
                  state_q   <= S_ST_WR;
                end else begin
                  state_q <= S_ST_RD;
                end
              end
            end else if (chk.is_io) begin
              rsp_rdata <= {{BTN_PAD{1'b0}}, btn_in};
              rsp_done  <= 1'b1;
            end else begin
              mem_en   <= 1'b1;
              mem_addr <= req_addr[RAM_AW-1:2];
              state_q  <= S_LD_WAIT;
            end
          end
        end
        S_LD_WAIT: state_q <= S_LD_CAP;
        S_LD_CAP: begin
          rsp_rdata <= ld_val;
          rsp_done  <= 1'b1;
          state_q   <= S_IDLE;
        end
        S_ST_RD: state_q <= S_ST_MRG;
        S_ST_MRG: begin
          mem_en    <= 1'b1;
          mem_we    <= 1'b1;
          mem_wdata <= merged;
          state_q   <= S_ST_WR;
        end
        S_ST_WR: begin
          rsp_done <= 1'b1;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R6: an error completion never coincides with a RAM or display access
  a_r6_err_no_access: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_done && !mem_en && !disp_we));

  // R7: display writes and RAM accesses are exclusive
  a_r7_io_excludes_ram: assert property (@(posedge clk) disable iff (rst)
    disp_we |-> !mem_en);

  // R9: read data only moves together with a completion
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(rsp_rdata) |-> rsp_done);

  // R4: a partial-lane write-back is preceded by a read two cycles before
  a_r4_read_before_merge: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we && be_q != 4'b1111) |-> ($past(mem_en, 2) && !$past(mem_we, 2)));

  // R3: a full-word write ends in completion on the next cycle
  a_r3_word_write_done: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |=> rsp_done);

endmodule

// File: tb/lsu_mem_port_tb.sv
module lsu_mem_port_tb;

  localparam int RAM_AW  = 17;
  localparam int BTN_W   = 4;
  localparam int WORD_AW = RAM_AW - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic               req_valid = 1'b0;
  logic               req_store = 1'b0;
  logic [31:0]        req_addr = '0;
  logic [31:0]        req_wdata = '0;
  logic [2:0]         req_ld_code = '0;
  logic [1:0]         req_st_code = '0;
  logic               rsp_done, rsp_err;
  logic [31:0]        rsp_rdata;
  logic               mem_en, mem_we;
  logic [WORD_AW-1:0] mem_addr;
  logic [31:0]        mem_wdata;
  logic [31:0]        mem_rdata = '0;
  logic               disp_we;
  logic [RAM_AW-1:0]  disp_addr;
  logic [3:0]         disp_be;
  logic [31:0]        disp_data;
  logic [BTN_W-1:0]   btn_in = 4'b1010;

  lsu_mem_port #(.RAM_AW(RAM_AW), .BTN_W(BTN_W)) u_dut (
    .clk, .rst, .req_valid, .req_store, .req_addr, .req_wdata,
    .req_ld_code, .req_st_code, .rsp_done, .rsp_err, .rsp_rdata,
    .mem_en, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
    .disp_we, .disp_addr, .disp_be, .disp_data, .btn_in
  );

  // external RAM model, 256 words seen through the low word-address bits
  logic [31:0] ram  [0:255];
  logic [31:0] gold [0:255];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr[7:0]];
    end
  end

  typedef struct { logic [31:0] rdata; logic err; int due; string tag; } rsp_item_t;
  typedef struct { logic [RAM_AW-1:0] a; logic [3:0] be; logic [31:0] d; string tag; } disp_item_t;
  rsp_item_t  rq[$];
  disp_item_t dq[$];
  rsp_item_t  mit;
  disp_item_t mdi;

  int checks = 0, fails = 0, cyc = 0, rsp_seen = 0, acc_cnt = 0;
  logic [31:0] last_rd = '0;

  // monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    cyc++;
    if (mem_en) acc_cnt++;
    if (!rst && rsp_done) begin
      checks++;
      if (rq.size() == 0) begin
        fails++;
        $display("FAIL R9: unexpected rsp_done, actual 1 expected 0");
      end else begin
        mit = rq.pop_front();
        if (rsp_rdata !== mit.rdata || rsp_err !== mit.err || cyc != mit.due) begin
          fails++;
          $display("FAIL %s: rdata=%h err=%b cyc=%0d expected rdata=%h err=%b cyc=%0d",
                   mit.tag, rsp_rdata, rsp_err, cyc, mit.rdata, mit.err, mit.due);
        end
      end
      rsp_seen++;
    end
    if (!rst && disp_we) begin
      checks++;
      if (dq.size() == 0) begin
        fails++;
        $display("FAIL R7: unexpected disp_we, actual 1 expected 0");
      end else begin
        mdi = dq.pop_front();
        if (disp_addr !== mdi.a || disp_be !== mdi.be || disp_data !== mdi.d) begin
          fails++;
          $display("FAIL %s: disp a=%h be=%b d=%h expected a=%h be=%b d=%h",
                   mdi.tag, disp_addr, disp_be, disp_data, mdi.a, mdi.be, mdi.d);
        end
      end
    end
  end

  // driver: computes expectations from the requirements and pushes them
  task automatic do_op(input logic st, input logic [31:0] a, input logic [31:0] wd,
                       input logic [2:0] lc, input logic [1:0] sc, input string tag);
    logic io, bad;
    int o, lat, acc_exp, acc0, n0, waited;
    logic [31:0] w, v, rep;
    logic [3:0] be;
    logic [7:0] idx;
    rsp_item_t it;
    disp_item_t di;
    io = |a[31:RAM_AW];
    o = int'(a[1:0]);
    idx = a[9:2];
    bad = 1'b0;
    be = 4'b0000;
    if (st) begin
      if (sc == 2'b01) be[o] = 1'b1;
      if (sc == 2'b10) begin bad = a[0]; be[o] = 1'b1; be[o|1] = 1'b1; end
      if (sc == 2'b11) begin bad = (a[1:0] != 2'b00); be = 4'b1111; end
    end else begin
      if (lc == 3'b001 || lc == 3'b101) bad = a[0];
      else if (lc == 3'b010) bad = (a[1:0] != 2'b00);
      else if (lc != 3'b000 && lc != 3'b100) bad = 1'b1;
    end
    v = last_rd;
    lat = 1;
    acc_exp = 0;
    if (!bad) begin
      if (st) begin
        if (sc != 2'b00) begin
          rep = (sc == 2'b01) ? {4{wd[7:0]}} : (sc == 2'b10) ? {2{wd[15:0]}} : wd;
          if (io) begin
            di.a = a[RAM_AW-1:0]; di.be = be; di.d = rep; di.tag = tag;
            dq.push_back(di);
          end else begin
            for (int b = 0; b < 4; b++) if (be[b]) gold[idx][8*b +: 8] = rep[8*b +: 8];
            lat = (sc == 2'b11) ? 2 : 4;
            acc_exp = (sc == 2'b11) ? 1 : 2;
          end
        end
      end else begin
        if (io) v = {28'd0, btn_in};
        else begin
          w = gold[idx];
          lat = 3;
          acc_exp = 1;
          case (lc)
            3'b000: v = {{24{w[8*o+7]}}, w[8*o +: 8]};
            3'b100: v = {24'd0, w[8*o +: 8]};
            3'b001: v = {{16{w[8*o+15]}}, w[8*o +: 16]};
            3'b101: v = {16'd0, w[8*o +: 16]};
            default: v = w;
          endcase
        end
        last_rd = v;
      end
    end
    it.rdata = v; it.err = bad; it.tag = tag;
    @(posedge clk); #1;
    it.due = cyc + 1 + lat;
    rq.push_back(it);
    acc0 = acc_cnt;
    n0 = rsp_seen;
    req_valid = 1'b1; req_store = st; req_addr = a; req_wdata = wd;
    req_ld_code = lc; req_st_code = sc;
    @(posedge clk); #1;
    req_valid = 1'b0;
    waited = 0;
    while (rsp_seen == n0 && waited < 50) begin
      @(posedge clk); #1;
      waited++;
    end
    if (waited >= 50) begin
      checks++; fails++;
      $display("FAIL %s: no completion, actual none expected rsp_done", tag);
      rq.delete();
    end
    checks++;
    if (acc_cnt - acc0 != acc_exp) begin
      fails++;
      $display("FAIL %s: RAM accesses actual %0d expected %0d", tag, acc_cnt - acc0, acc_exp);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not end, actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i]  = 32'h5A3C_96E1 ^ (i * 32'h9E37_79B1);
      gold[i] = 32'h5A3C_96E1 ^ (i * 32'h9E37_79B1);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rsp_done !== 1'b0 || rsp_err !== 1'b0 || mem_en !== 1'b0 || mem_we !== 1'b0 ||
        disp_we !== 1'b0 || rsp_rdata !== 32'd0) begin
      fails++;
      $display("FAIL R1: done=%b err=%b en=%b we=%b dwe=%b rd=%h expected all zero",
               rsp_done, rsp_err, mem_en, mem_we, disp_we, rsp_rdata);
    end
    @(posedge clk); #1 rst = 1'b0;

    // R3: word store then word load
    do_op(1'b1, 32'h0000_0040, 32'h80F1_7F01, 3'b000, 2'b11, "R3 word store");
    do_op(1'b0, 32'h0000_0040, 32'h0,         3'b010, 2'b00, "R3 word load");
    // R2: byte lanes, signed and unsigned
    for (int k = 0; k < 4; k++) begin
      do_op(1'b0, 32'h40 + k, 32'h0, 3'b000, 2'b00, "R2 signed byte");
      do_op(1'b0, 32'h40 + k, 32'h0, 3'b100, 2'b00, "R2 unsigned byte");
    end
    do_op(1'b0, 32'h0000_0040, 32'h0, 3'b001, 2'b00, "R2 signed half lo");
    do_op(1'b0, 32'h0000_0042, 32'h0, 3'b001, 2'b00, "R2 signed half hi");
    do_op(1'b0, 32'h0000_0042, 32'h0, 3'b101, 2'b00, "R2 unsigned half hi");
    do_op(1'b0, 32'h0000_0080, 32'h0, 3'b101, 2'b00, "R2 unsigned half preset");
    // R4: sub-word stores into the same word, then read back
    do_op(1'b1, 32'h0000_0041, 32'hFFFF_FFAB, 3'b000, 2'b01, "R4 byte store lane1");
    do_op(1'b0, 32'h0000_0040, 32'h0,         3'b010, 2'b00, "R4 readback");
    do_op(1'b1, 32'h0000_0042, 32'h1234_C3D4, 3'b000, 2'b10, "R4 half store hi");
    do_op(1'b1, 32'h0000_0040, 32'h0000_0077, 3'b000, 2'b01, "R4 byte store lane0");
    do_op(1'b0, 32'h0000_0040, 32'h0,         3'b010, 2'b00, "R4 readback merged");
    do_op(1'b1, 32'h0000_0087, 32'h0000_00E5, 3'b000, 2'b01, "R4 byte store lane3");
    do_op(1'b0, 32'h0000_0084, 32'h0,         3'b010, 2'b00, "R4 readback lane3");
    // R5: no-write store leaves the word alone
    do_op(1'b1, 32'h0000_0040, 32'hDEAD_BEEF, 3'b000, 2'b00, "R5 store none");
    do_op(1'b0, 32'h0000_0040, 32'h0,         3'b010, 2'b00, "R5 readback");
    // R6: misaligned and undefined codes
    do_op(1'b0, 32'h0000_0041, 32'h0,         3'b001, 2'b00, "R6 half load odd");
    do_op(1'b0, 32'h0000_0042, 32'h0,         3'b010, 2'b00, "R6 word load off2");
    do_op(1'b1, 32'h0000_0043, 32'h1111_1111, 3'b000, 2'b10, "R6 half store odd");
    do_op(1'b1, 32'h0000_0046, 32'h2222_2222, 3'b000, 2'b11, "R6 word store off2");
    do_op(1'b0, 32'h0000_0040, 32'h0,         3'b011, 2'b00, "R6 load code 011");
    do_op(1'b0, 32'h0000_0040, 32'h0,         3'b110, 2'b00, "R6 load code 110");
    do_op(1'b0, 32'h0000_0040, 32'h0,         3'b010, 2'b00, "R6 word unchanged");
    // R7/R8: I/O region just above RAM and far above
    do_op(1'b1, 32'h0002_0010, 32'hCAFE_0042, 3'b000, 2'b11, "R7 io word store");
    do_op(1'b1, 32'h8000_0003, 32'h0000_005C, 3'b000, 2'b01, "R7 io byte store");
    do_op(1'b1, 32'h0002_0006, 32'h0000_9A9B, 3'b000, 2'b10, "R7 io half store");
    do_op(1'b0, 32'hFFFF_FFF0, 32'h0,         3'b010, 2'b00, "R8 button load");
    btn_in = 4'b0101;
    do_op(1'b0, 32'h0002_0000, 32'h0,         3'b100, 2'b00, "R8 button load 2");
    do_op(1'b1, 32'h0002_0001, 32'h3333_3333, 3'b000, 2'b11, "R6 io word misaligned");
    // boundary: last RAM word
    do_op(1'b1, 32'h0001_FFFC, 32'h0BAD_F00D, 3'b000, 2'b11, "R3 last word store");
    do_op(1'b0, 32'h0001_FFFF, 32'h0,         3'b000, 2'b00, "R10 last byte load");
    do_op(1'b0, 32'h0000_0040, 32'h0,         3'b010, 2'b00, "R9 final load");

    repeat (3) @(posedge clk);
    checks++;
    if (dq.size() != 0 || rq.size() != 0) begin
      fails++;
      $display("FAIL R7: leftover items actual %0d/%0d expected 0/0", dq.size(), rq.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule